// File: doc/BRIEF.md
# Flash Program and Erase Controller

This block sequences program and erase operations on a small on-chip flash array. The array sits inside the block as a register file of 16-bit cells. Cells that have been erased read as all ones. Software reaches the block through a 32-bit register port that carries a key register, a status register, a control register and an erase-address register. The same port, with `bus_mem` set, reaches the flash array for reads and for halfword programming.

Out of reset the controller is locked. Software unlocks it with a two-word key sequence. It then selects halfword programming, page erase or mass erase in the control register. Every operation is screened before it begins. Three faults each raise their own sticky flag, and in each case the operation never starts: an unaligned or wrongly sized program write, a target page that the `wp_mask` input protects, and a program target that is not erased. An accepted operation holds BUSY for a fixed number of cycles, then updates the array and raises an end flag. The interrupt line combines the flags with two enables. An option-reload request appears as a one-cycle `rst_req` pulse.

Every port is a plain control or status pin. The register port has no back-pressure: each access completes in the cycle it is presented, and reads return combinationally.

Top module: `flash_pe_ctl`

## Requirements
- R1: After reset the control register (offset 0x10) reads 0x00000080 (lock bit 7 set), the status register (offset 0x0C) reads 0, `irq` and `rst_req` are 0, and every flash cell reads 0xFFFF.
- R2: Writing 0x5A5A1234 and then 0xA5A5CDEF to the key register (offset 0x04) clears the lock. Any other word written while locked keeps the lock set until reset, even if a correct sequence follows.
- R3: While the lock is set, writes to the control register and to the address register (offset 0x14) are ignored. Writing 1 to bit 7 of the control register while unlocked sets the lock again.
- R4: Register writes that are not 32-bit (`bus_size` other than 2) are ignored.
- R5: With program enable set (control bit 0), a halfword write (`bus_size`=1) to an even flash address holding 0xFFFF holds BUSY (status bit 0) for PROG_CYC cycles. The cell then holds the data and ENDF (status bit 5) is set.
- R6: A program write that is not halfword-sized, or that is at an odd address, sets PGAERR (status bit 3) and leaves the array and BUSY unchanged. This check takes priority over the protection check.
- R7: A program write to a cell that does not read 0xFFFF sets PGERR (status bit 2), and the cell is unchanged.
- R8: A program or erase that targets a page whose `wp_mask` bit is 1 sets WPERR (status bit 4) and is not carried out.
- R9: Writing the control register with page erase (bit 1) and start (bit 6) erases the page that holds the byte address in the address register. BUSY is held for ERASE_CYC cycles. Start reads 1 while the erase runs. Other pages are untouched.
- R10: Mass erase (bit 2) with start erases the whole array and takes priority over page erase. If any page is protected it sets WPERR and erases nothing.
- R11: The status flags in bits 5:2 are cleared only by a 32-bit write of 1 to their own position. Writing 0 has no effect.
- R12: `irq` is 1 when ENDF and the end enable (control bit 12) are both 1, or when any error flag and the error enable (control bit 10) are both 1.
- R13: Writing 1 to control bit 13 while unlocked gives a one-cycle `rst_req` pulse in the following cycle. Bit 13 reads 0, and writing 0 gives no pulse.
- R14: While BUSY is 1, control writes, address writes and flash program writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_mem | input | 1 | 1 = flash array, 0 = registers |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | BUS_AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| wp_mask | input | PAGES | 1 marks a page as protected |
| irq | output | 1 | Interrupt request |
| rst_req | output | 1 | One-cycle reload and reset request |

## Verification
Error flags, register updates and the start of BUSY all come from the write edge itself, so the bench samples them on the falling edge right after that write. `rst_req` is valid for exactly that half-cycle and is checked low again one falling edge later. BUSY is checked high on the falling edges after write edges 0 through N-1, where N is PROG_CYC or ERASE_CYC. On the falling edge after edge N the bench checks BUSY low, ENDF set and the array updated. The writes that must be ignored during BUSY are placed on edges that fall strictly inside that window.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
  localparam logic [7:0] OFS_KEY  = 8'h04;
  localparam logic [7:0] OFS_STAT = 8'h0C;
  localparam logic [7:0] OFS_CTL  = 8'h10;
  localparam logic [7:0] OFS_ADDR = 8'h14;

  localparam logic [31:0] UNLOCK_W1 = 32'h5A5A_1234;
  localparam logic [31:0] UNLOCK_W2 = 32'hA5A5_CDEF;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // control bit positions
  localparam int C_PROG   = 0;
  localparam int C_PAGE   = 1;
  localparam int C_MASS   = 2;
  localparam int C_GO     = 6;
  localparam int C_LOCK   = 7;
  localparam int C_ERR_IE = 10;
  localparam int C_END_IE = 12;
  localparam int C_RELOAD = 13;
  // bits held as plain storage (includes the option-area bits 4, 5, 9)
  localparam logic [31:0] CTL_KEEP = 32'h0000_1637;

  typedef enum logic [1:0] {OP_PROG, OP_PAGE, OP_MASS} op_e;
endpackage

// File: rtl/flash_pe_key.sv
module flash_pe_key
  import flash_pe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_we,
  input  logic [31:0] key_data,
  input  logic        lock_set,
  output logic        locked
);
  logic stage, dead;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b1;
      stage  <= 1'b0;
      dead   <= 1'b0;
    end else if (lock_set) begin
      locked <= 1'b1;
      stage  <= 1'b0;
    end else if (key_we && locked && !dead) begin
      if (!stage) begin
        if (key_data == UNLOCK_W1) stage <= 1'b1;
        else                       dead  <= 1'b1;
      end else begin
        stage <= 1'b0;
        if (key_data == UNLOCK_W2) locked <= 1'b0;
        else                       dead   <= 1'b1;
      end
    end
  end

  // R2: lock can only drop on a key write
  a_r2_lock_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !key_we) |=> locked);
  // R2: a bad key keeps the block locked
  a_r2_bad_key_stays: assert property (@(posedge clk) disable iff (!rst_n)
    dead |-> locked);
endmodule

// File: rtl/flash_pe_flags.sv
module flash_pe_flags (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        busy,
  input  logic        set_end,
  input  logic        set_wp,
  input  logic        set_pga,
  input  logic        set_pg,
  input  logic        clr_we,
  input  logic [5:2]  clr_bits,
  input  logic        end_ie,
  input  logic        err_ie,
  output logic [31:0] stat,
  output logic        irq
);
  logic f_end, f_wp, f_pga, f_pg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_end <= 1'b0;
      f_wp  <= 1'b0;
      f_pga <= 1'b0;
      f_pg  <= 1'b0;
    end else begin
      f_end <= set_end | (f_end & ~(clr_we & clr_bits[5]));
      f_wp  <= set_wp  | (f_wp  & ~(clr_we & clr_bits[4]));
      f_pga <= set_pga | (f_pga & ~(clr_we & clr_bits[3]));
      f_pg  <= set_pg  | (f_pg  & ~(clr_we & clr_bits[2]));
    end
  end

  assign stat = {26'd0, f_end, f_wp, f_pga, f_pg, 1'b0, busy};
  assign irq  = (end_ie & f_end) | (err_ie & (f_wp | f_pga | f_pg));

  // R11: flags are sticky unless their own bit is written with 1
  a_r11_end_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (f_end && !(clr_we && clr_bits[5])) |=> f_end);
  a_r11_wp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (f_wp && !(clr_we && clr_bits[4])) |=> f_wp);
  a_r11_pg_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (f_pg && !(clr_we && clr_bits[2])) |=> f_pg);
  // R12: no interrupt without a raised flag
  a_r12_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (f_end || f_wp || f_pga || f_pg));
endmodule

// File: rtl/flash_pe_core.sv
module flash_pe_core
  import flash_pe_pkg::*;
#(
  parameter int PAGES     = 4,
  parameter int HWPP      = 8,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 8,
  localparam int CELLS = PAGES * HWPP,
  localparam int HW_AW = $clog2(CELLS),
  localparam int PG_W  = $clog2(PAGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_req,
  input  logic             prog_aligned,
  input  logic [HW_AW-1:0] prog_idx,
  input  logic [15:0]      prog_data,
  input  logic             erase_req,
  input  logic             erase_mass,
  input  logic [PG_W-1:0]  erase_page,
  input  logic [PAGES-1:0] wp_mask,
  input  logic [HW_AW-2:0] rd_widx,
  output logic [31:0]      rd_word,
  output logic             busy,
  output logic             erase_busy,
  output logic             done,
  output logic             err_wp,
  output logic             err_align,
  output logic             err_prog
);
  localparam int CNT_MAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [15:0]      mem [CELLS];
  logic [CNT_W-1:0] cnt;
  op_e              op;
  logic [HW_AW-1:0] tgt_idx;
  logic [PG_W-1:0]  tgt_page;
  logic [15:0]      tgt_data;

  logic p_prot, e_prot, cell_used, acc_p, acc_e;

  always_comb begin
    p_prot    = wp_mask[prog_idx[HW_AW-1 -: PG_W]];
    e_prot    = erase_mass ? (|wp_mask) : wp_mask[erase_page];
    cell_used = (mem[prog_idx] != 16'hFFFF);
    err_align = prog_req && !prog_aligned;
    err_wp    = (prog_req && prog_aligned && p_prot) || (erase_req && e_prot);
    err_prog  = prog_req && prog_aligned && !p_prot && cell_used;
    acc_p     = prog_req && prog_aligned && !p_prot && !cell_used;
    acc_e     = erase_req && !e_prot;
  end

  assign done       = busy && (cnt == '0);
  assign erase_busy = busy && (op != OP_PROG);
  assign rd_word    = {mem[{rd_widx, 1'b1}], mem[{rd_widx, 1'b0}]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      op       <= OP_PROG;
      tgt_idx  <= '0;
      tgt_page <= '0;
      tgt_data <= '0;
    end else if (acc_p) begin
      busy     <= 1'b1;
      cnt      <= CNT_W'(PROG_CYC - 1);
      op       <= OP_PROG;
      tgt_idx  <= prog_idx;
      tgt_data <= prog_data;
    end else if (acc_e) begin
      busy     <= 1'b1;
      cnt      <= CNT_W'(ERASE_CYC - 1);
      op       <= erase_mass ? OP_MASS : OP_PAGE;
      tgt_page <= erase_page;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < CELLS; i++) mem[i] <= 16'hFFFF;
    end else if (done) begin
      for (int i = 0; i < CELLS; i++) begin
        case (op)
          OP_PROG: if (HW_AW'(i) == tgt_idx) mem[i] <= tgt_data;
          OP_PAGE: if (PG_W'(i / HWPP) == tgt_page) mem[i] <= 16'hFFFF;
          default: mem[i] <= 16'hFFFF;
        endcase
      end
    end
  end

  // R6/R7/R8: a rejected request never leaves BUSY high
  a_r6_error_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (err_wp || err_align || err_prog) |=> !busy);
  // R7: a program only lands on a cell that is still erased
  a_r7_prog_onto_erased: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op == OP_PROG) |-> (mem[tgt_idx] == 16'hFFFF));
  // R14: no new operation is taken while one runs
  a_r14_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(prog_req || erase_req));
endmodule

// File: rtl/flash_pe_ctl.sv
module flash_pe_ctl
  import flash_pe_pkg::*;
#(
  parameter int PAGES     = 4,
  parameter int HWPP      = 8,
  parameter int PROG_CYC  = 4,
  parameter int ERASE_CYC = 8,
  parameter int BUS_AW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic              bus_mem,
  input  logic [1:0]        bus_size,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [PAGES-1:0]  wp_mask,
  output logic              irq,
  output logic              rst_req
);
  localparam int CELLS  = PAGES * HWPP;
  localparam int HW_AW  = $clog2(CELLS);
  localparam int PG_W   = $clog2(PAGES);
  localparam int HWPP_W = $clog2(HWPP);

  logic [31:0]       ctl_q, stat, rd_word;
  logic [BUS_AW-1:0] addr_q;
  logic              locked, busy, erase_busy, done;
  logic              err_wp, err_align, err_prog;
  logic              reg_wr, key_we, stat_we, ctl_hit, ctl_wr, addr_wr;
  logic              prog_req, erase_req;

  always_comb begin
    reg_wr    = bus_en && bus_wr && !bus_mem && (bus_size == SZ_WORD);
    key_we    = reg_wr && (bus_addr == BUS_AW'(OFS_KEY));
    stat_we   = reg_wr && (bus_addr == BUS_AW'(OFS_STAT));
    ctl_hit   = reg_wr && (bus_addr == BUS_AW'(OFS_CTL));
    ctl_wr    = ctl_hit && !locked && !busy;
    addr_wr   = reg_wr && (bus_addr == BUS_AW'(OFS_ADDR)) && !locked && !busy;
    erase_req = ctl_wr && bus_wdata[C_GO] && (bus_wdata[C_MASS] || bus_wdata[C_PAGE]);
    prog_req  = bus_en && bus_wr && bus_mem && ctl_q[C_PROG] && !locked && !busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      addr_q  <= '0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= ctl_wr && bus_wdata[C_RELOAD];
      if (ctl_wr)  ctl_q  <= bus_wdata & CTL_KEEP;
      if (addr_wr) addr_q <= bus_wdata[BUS_AW-1:0];
    end
  end

  flash_pe_key u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_we   (key_we),
    .key_data (bus_wdata),
    .lock_set (ctl_wr && bus_wdata[C_LOCK]),
    .locked   (locked)
  );

  flash_pe_core #(
    .PAGES(PAGES), .HWPP(HWPP), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)
  ) u_core (
    .clk          (clk),
    .rst_n        (rst_n),
    .prog_req     (prog_req),
    .prog_aligned ((bus_size == SZ_HALF) && !bus_addr[0]),
    .prog_idx     (bus_addr[HW_AW:1]),
    .prog_data    (bus_wdata[15:0]),
    .erase_req    (erase_req),
    .erase_mass   (bus_wdata[C_MASS]),
    .erase_page   (addr_q[HWPP_W+1 +: PG_W]),
    .wp_mask      (wp_mask),
    .rd_widx      (bus_addr[HW_AW:2]),
    .rd_word      (rd_word),
    .busy         (busy),
    .erase_busy   (erase_busy),
    .done         (done),
    .err_wp       (err_wp),
    .err_align    (err_align),
    .err_prog     (err_prog)
  );

  flash_pe_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .set_end  (done),
    .set_wp   (err_wp),
    .set_pga  (err_align),
    .set_pg   (err_prog),
    .clr_we   (stat_we),
    .clr_bits (bus_wdata[5:2]),
    .end_ie   (ctl_q[C_END_IE]),
    .err_ie   (ctl_q[C_ERR_IE]),
    .stat     (stat),
    .irq      (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_mem) bus_rdata = rd_word;
    else if (bus_addr == BUS_AW'(OFS_STAT)) bus_rdata = stat;
    else if (bus_addr == BUS_AW'(OFS_CTL))
      bus_rdata = ctl_q | (32'(locked) << C_LOCK) | (32'(erase_busy) << C_GO);
    else if (bus_addr == BUS_AW'(OFS_ADDR)) bus_rdata = 32'(addr_q);
  end

  // R3: control contents hold while locked
  a_r3_locked_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && ctl_hit) |=> $stable(ctl_q));
  // R4: narrow register writes change nothing
  a_r4_narrow_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_wr && !bus_mem && bus_size != SZ_WORD) |=> ($stable(ctl_q) && $stable(addr_q)));
  // R13: the reset request only follows an accepted reload write
  a_r13_reload_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(ctl_wr && bus_wdata[C_RELOAD]));
endmodule

// File: tb/flash_pe_ctl_tb.sv
module flash_pe_ctl_tb;
  localparam int PAGES = 4, HWPP = 8, PROG_CYC = 4, ERASE_CYC = 8;
  localparam int CELLS = PAGES * HWPP;
  localparam logic [7:0] A_KEY = 8'h04, A_STAT = 8'h0C, A_CTL = 8'h10, A_ADDR = 8'h14;
  localparam logic [1:0] BYTE = 2'd0, HALF = 2'd1, WORD = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 0, bus_wr = 0, bus_mem = 0;
  logic [1:0] bus_size = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [PAGES-1:0] wp_mask = 4'b1000;
  logic irq, rst_req;

  int n_chk = 0, n_fail = 0;
  logic [15:0] m [CELLS];

  always #5 clk = ~clk;

  flash_pe_ctl #(.PAGES(PAGES), .HWPP(HWPP), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC))
  u_dut (.clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr), .bus_mem(bus_mem),
         .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
         .bus_rdata(bus_rdata), .wp_mask(wp_mask), .irq(irq), .rst_req(rst_req));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic mem, input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_wr = 1; bus_mem = mem; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic mem, input logic [7:0] a, output logic [31:0] d);
    bus_en = 1; bus_wr = 0; bus_mem = mem; bus_addr = a; bus_size = WORD;
    #1 d = bus_rdata;
    bus_en = 0;
  endtask

  task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(1'b0, a, d);
    chk(req, d, exp);
  endtask

  task automatic chk_array(input string req);
    logic [31:0] d;
    for (int w = 0; w < CELLS / 2; w++) begin
      rd(1'b1, 8'(w * 4), d);
      chk(req, d, {m[2*w+1], m[2*w]});
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < CELLS; i++) m[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    chk_reg("R1 ctl", A_CTL, 32'h80);
    chk_reg("R1 stat", A_STAT, 32'h0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rst_req", 32'(rst_req), 0);
    chk_array("R1 array erased");

    // R3 locked writes ignored
    wr(0, A_CTL, WORD, 32'h1);
    chk_reg("R3 ctl locked", A_CTL, 32'h80);
    wr(0, A_ADDR, WORD, 32'h10);
    chk_reg("R3 addr locked", A_ADDR, 32'h0);

    // R2 unlock
    wr(0, A_KEY, WORD, 32'h5A5A1234);
    wr(0, A_KEY, WORD, 32'hA5A5CDEF);
    chk_reg("R2 unlocked", A_CTL, 32'h0);

    // R4 narrow write ignored
    wr(0, A_CTL, HALF, 32'h1);
    chk_reg("R4 narrow ctl", A_CTL, 32'h0);

    // R5/R12 first program with no enables
    wr(0, A_CTL, WORD, 32'h1);
    wr(1, 8'h00, HALF, 32'h0A00);
    m[0] = 16'h0A00;
    repeat (PROG_CYC) @(negedge clk);
    chk_reg("R5 end flag", A_STAT, 32'h20);
    chk("R12 irq disabled", 32'(irq), 0);
    wr(0, A_CTL, WORD, 32'h1401);
    chk("R12 irq end", 32'(irq), 1);
    wr(0, A_STAT, WORD, 32'h20);
    chk("R12 irq cleared", 32'(irq), 0);

    // R5 sweep over the unprotected cells
    for (int i = 1; i < 3 * HWPP; i++) begin
      logic [15:0] v;
      v = 16'h0A00 + 16'(i * 7);
      wr(1, 8'(i * 2), HALF, 32'(v));
      chk_reg("R5 busy start", A_STAT, 32'h1);
      repeat (PROG_CYC - 1) @(negedge clk);
      chk_reg("R5 busy last", A_STAT, 32'h1);
      @(negedge clk);
      chk_reg("R5 done", A_STAT, 32'h20);
      wr(0, A_STAT, WORD, 32'h20);
      m[i] = v;
    end
    chk_array("R5 array");

    // R7 program over used cell, R11 clear rules
    wr(1, 8'h00, HALF, 32'h0);
    chk_reg("R7 pgerr", A_STAT, 32'h04);
    chk("R12 irq error", 32'(irq), 1);
    wr(0, A_STAT, WORD, 32'h0);
    chk_reg("R11 write zero", A_STAT, 32'h04);
    wr(0, A_STAT, WORD, 32'h20);
    chk_reg("R11 other bit", A_STAT, 32'h04);
    wr(0, A_STAT, WORD, 32'h04);
    chk_reg("R11 cleared", A_STAT, 32'h0);

    // R6 alignment / size errors, including protected page
    wr(1, 8'h02, BYTE, 32'h0);
    chk_reg("R6 byte", A_STAT, 32'h08);
    wr(0, A_STAT, WORD, 32'h3C);
    wr(1, 8'h03, HALF, 32'h0);
    chk_reg("R6 odd", A_STAT, 32'h08);
    wr(0, A_STAT, WORD, 32'h3C);
    wr(1, 8'h04, WORD, 32'h0);
    chk_reg("R6 word", A_STAT, 32'h08);
    wr(0, A_STAT, WORD, 32'h3C);
    wr(1, 8'h31, HALF, 32'h0);
    chk_reg("R6 priority over protect", A_STAT, 32'h08);
    wr(0, A_STAT, WORD, 32'h3C);

    // R8 protected page program
    wr(1, 8'h30, HALF, 32'h0);
    chk_reg("R8 wperr", A_STAT, 32'h10);
    wr(0, A_STAT, WORD, 32'h3C);
    chk_array("R6 R7 R8 array unchanged");

    // R9 page erase of page 1, R14 writes during erase
    wr(0, A_ADDR, WORD, 32'h10);
    wr(0, A_CTL, WORD, 32'h1442);
    chk_reg("R9 start reads 1", A_CTL, 32'h1442);
    wr(0, A_ADDR, WORD, 32'h20);
    wr(0, A_CTL, WORD, 32'h1401);
    repeat (3) @(negedge clk);
    chk_reg("R9 still busy", A_STAT, 32'h1);
    @(negedge clk);
    chk_reg("R9 done", A_STAT, 32'h20);
    chk_reg("R14 ctl kept", A_CTL, 32'h1402);
    chk_reg("R14 addr kept", A_ADDR, 32'h10);
    for (int i = HWPP; i < 2 * HWPP; i++) m[i] = 16'hFFFF;
    chk_array("R9 page erased");
    wr(0, A_STAT, WORD, 32'h20);

    // R14 program write while programming is ignored
    wr(0, A_CTL, WORD, 32'h1401);
    wr(1, 8'h10, HALF, 32'h5555);
    wr(1, 8'h12, HALF, 32'h6666);
    repeat (2) @(negedge clk);
    chk_reg("R14 stat", A_STAT, 32'h20);
    m[8] = 16'h5555;
    chk_array("R14 second write dropped");
    wr(0, A_STAT, WORD, 32'h20);

    // R10 mass erase blocked by protection
    wr(0, A_CTL, WORD, 32'h1444);
    chk_reg("R10 wperr", A_STAT, 32'h10);
    chk_array("R10 nothing erased");
    wr(0, A_STAT, WORD, 32'h10);
    wp_mask = 4'b0000;
    wr(0, A_CTL, WORD, 32'h1446);
    chk_reg("R10 busy start", A_STAT, 32'h1);
    repeat (ERASE_CYC - 1) @(negedge clk);
    chk_reg("R10 busy last", A_STAT, 32'h1);
    @(negedge clk);
    chk_reg("R10 done", A_STAT, 32'h20);
    for (int i = 0; i < CELLS; i++) m[i] = 16'hFFFF;
    chk_array("R10 all erased");
    wr(0, A_STAT, WORD, 32'h20);

    // R3 relock
    wr(0, A_CTL, WORD, 32'h80);
    chk_reg("R3 relocked", A_CTL, 32'h80);
    wr(0, A_CTL, WORD, 32'h1);
    chk_reg("R3 ctl ignored", A_CTL, 32'h80);
    wr(0, A_ADDR, WORD, 32'h30);
    chk_reg("R3 addr ignored", A_ADDR, 32'h10);

    // R13 reload pulse
    wr(0, A_KEY, WORD, 32'h5A5A1234);
    wr(0, A_KEY, WORD, 32'hA5A5CDEF);
    wr(0, A_CTL, WORD, 32'h2000);
    chk("R13 pulse", 32'(rst_req), 1);
    chk_reg("R13 reads zero", A_CTL, 32'h0);
    @(negedge clk);
    chk("R13 one cycle", 32'(rst_req), 0);
    wr(0, A_CTL, WORD, 32'h0);
    chk("R13 no pulse on zero", 32'(rst_req), 0);

    // R2 wrong key locks until reset
    wr(0, A_CTL, WORD, 32'h80);
    wr(0, A_KEY, WORD, 32'h12345678);
    wr(0, A_KEY, WORD, 32'h5A5A1234);
    wr(0, A_KEY, WORD, 32'hA5A5CDEF);
    chk_reg("R2 bad key stays locked", A_CTL, 32'h80);
    wr(0, A_CTL, WORD, 32'h1);
    chk_reg("R2 still ignored", A_CTL, 32'h80);

    finish_run();
  end
endmodule